// File: doc/BRIEF.md
# Byte-Synchronous Serial Transmitter with Gated CRC Trailer

This block turns a stream of bytes into a continuous synchronous bit stream. A processor writes data bytes into a four-entry FIFO. Whenever the shifter is empty and the transmitter is enabled, the next character is chosen and shifted out MSB first, one bit per `bit_en_i` pulse. That character is a FIFO byte, a CRC trailer byte, or the programmable sync character. When no data is waiting, the line is filled with the sync character, so the stream never has gaps.

A 16-bit CRC accumulator folds in data bytes only. The enable for each byte is sampled at the moment the byte leaves the FIFO. The accumulator is cleared only by an explicit command. The end of a message is marked by an underrun, which happens when the FIFO is empty while the shifter needs a new character. At that point, if the end-of-message latch is clear, the two CRC bytes are sent and the latch is then set. If the latch is already set, sync characters are sent instead. Software clears the latch by command, or the block clears it on a data write when the auto-clear option is on.

Top module: `bsync_tx`

## Requirements
- R1: After reset, `sdo_o`=1, `eom_o`=1, `ovf_o`=0, `eom_irq_o`=0, `tx_irq_o`=1, and the sync register and CRC accumulator are zero.
- R2: Characters go out MSB first, one bit per cycle with `bit_en_i`=1. `sdo_o` does not change in a cycle without `bit_en_i`. When the transmitter is disabled and no character is in progress, `sdo_o` is 1.
- R3: When the FIFO is empty and the end-of-message latch is set, the sync register (write address 1) is sent. Sync characters never change the CRC.
- R4: The CRC uses polynomial 0x8005 (x^16+x^15+x^2+1), is not reflected, and takes data bits MSB first. The trailer is the high byte followed by the low byte.
- R5: A data byte is folded into the CRC only if crc_en (control bit 1) is 1 in the cycle that byte is loaded into the shifter. Its value at write time has no effect.
- R6: The accumulator is set to 0 only by command 2'b01. Sending a trailer does not preset it.
- R7: On underrun with the latch clear, the trailer is sent and the latch is set as its low byte is loaded. `eom_irq_o` pulses for exactly one cycle on that rise.
- R8: The latch is cleared by command 2'b10. It is also cleared by a data write (address 0) while auto_clr (control bit 3) is 1. A data write with auto_clr=0 leaves it set.
- R9: Clearing tx_en (control bit 0) in the middle of a character lets that character finish in full. After that, the line idles at 1.
- R10: The FIFO holds 4 bytes. A data write while it is full is dropped and sets the sticky `ovf_o`, which only reset clears.
- R11: With irq_empty (control bit 2) at 0, `tx_irq_o` means the FIFO is not full. With irq_empty at 1, `tx_irq_o` means the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 data FIFO, 1 sync character, 2 control |
| wr_data_i | input | 8 | Write data; control uses bits 3:0 |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | 2'b01 clear CRC, 2'b10 clear end-of-message latch |
| bit_en_i | input | 1 | Bit-clock enable, one bit per asserted cycle |
| sdo_o | output | 1 | Serial data out |
| eom_o | output | 1 | End-of-message latch |
| eom_irq_o | output | 1 | One-cycle pulse when the latch sets |
| tx_irq_o | output | 1 | Transmit buffer interrupt |
| ovf_o | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions check the following on every cycle:
- `sdo_o` holds its value between bit enables.
- The overflow flag is sticky.
- The FIFO occupancy stays within its depth.
- The latch only falls after a clear command or a data write.
- Each rise of the latch comes with a single-cycle interrupt pulse.

Only the scenarios can show the content of the stream:
- the CRC value against a polynomial model;
- that the CRC enable is sampled at load time;
- that sync characters are excluded and the accumulator is not preset;
- how the trailer is ordered;
- that a disabled character is finished in full.

// File: rtl/bsync_tx_pkg.sv
package bsync_tx_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_SYNC = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam logic [1:0] CMD_RST_CRC = 2'b01;
  localparam logic [1:0] CMD_RST_EOM = 2'b10;

  typedef enum logic [1:0] {
    SRC_SYNC,
    SRC_DATA,
    SRC_CRC_HI,
    SRC_CRC_LO
  } src_e;

  typedef struct packed {
    logic auto_clr;
    logic irq_empty;
    logic crc_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/bsync_tx_fifo.sv
module bsync_tx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [W-1:0]                   data_i,
  input  logic                           pop_i,
  output logic [W-1:0]                   data_o,
  output logic                           empty_o,
  output logic                           full_o,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign cnt_o   = cnt;
  assign data_o  = mem[rd_ptr];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/bsync_tx_crc.sv
module bsync_tx_crc #(
  parameter int unsigned        DATA_W = 8,
  parameter int unsigned        CRC_W  = 16,
  parameter logic [CRC_W-1:0]   POLY   = 16'h8005
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] c;
  logic             fb;

  // bit-serial update unrolled over one character, MSB first
  always_comb begin
    c  = crc_i;
    fb = 1'b0;
    for (int i = DATA_W-1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/bsync_tx.sv
module bsync_tx
  import bsync_tx_pkg::*;
#(
  parameter int unsigned           DATA_W     = 8,
  parameter int unsigned           FIFO_DEPTH = 4,
  parameter logic [2*DATA_W-1:0]   CRC_POLY   = 16'h8005
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              bit_en_i,
  output logic              sdo_o,
  output logic              eom_o,
  output logic              eom_irq_o,
  output logic              tx_irq_o,
  output logic              ovf_o
);
  localparam int unsigned CRC_W = 2*DATA_W;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam int unsigned CTL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] sync_q;
  logic [CRC_W-1:0]  crc_q, crc_next;
  logic              eom_q, eom_irq_q, ovf_q, lo_pend_q;
  logic [DATA_W-2:0] sreg_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic              sdo_q;

  logic              data_wr, push, pop, load;
  logic              fifo_empty, fifo_full;
  logic [DATA_W-1:0] fifo_dout, load_byte;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              cmd_rst_crc, cmd_rst_eom;
  src_e              src;

  assign data_wr     = wr_en_i && (wr_addr_i == ADDR_DATA);
  assign push        = data_wr && !fifo_full;
  assign cmd_rst_crc = cmd_valid_i && (cmd_i == CMD_RST_CRC);
  assign cmd_rst_eom = cmd_valid_i && (cmd_i == CMD_RST_EOM);
  assign load        = bit_en_i && (bit_cnt_q == '0) && ctrl_q.tx_en;
  assign pop         = load && (src == SRC_DATA);

  bsync_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (fifo_dout),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .cnt_o   (fifo_cnt)
  );

  bsync_tx_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .crc_i  (crc_q),
    .data_i (fifo_dout),
    .crc_o  (crc_next)
  );

  // source priority: finish trailer, then data, then trailer start, else sync
  always_comb begin
    if (lo_pend_q)        src = SRC_CRC_LO;
    else if (!fifo_empty) src = SRC_DATA;
    else if (!eom_q)      src = SRC_CRC_HI;
    else                  src = SRC_SYNC;
    case (src)
      SRC_DATA:   load_byte = fifo_dout;
      SRC_CRC_HI: load_byte = crc_q[CRC_W-1:DATA_W];
      SRC_CRC_LO: load_byte = crc_q[DATA_W-1:0];
      default:    load_byte = sync_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sync_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_SYNC) sync_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data_i[CTL_W-1:0]);
      if (data_wr && fifo_full)              ovf_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q     <= '0;
      eom_q     <= 1'b1;
      eom_irq_q <= 1'b0;
      lo_pend_q <= 1'b0;
    end else begin
      eom_irq_q <= 1'b0;
      if (cmd_rst_crc)                           crc_q <= '0;
      else if (pop && ctrl_q.crc_en)             crc_q <= crc_next;
      if (load && src == SRC_CRC_HI)             lo_pend_q <= 1'b1;
      else if (load && src == SRC_CRC_LO)        lo_pend_q <= 1'b0;
      if (load && src == SRC_CRC_LO) begin
        eom_q     <= 1'b1;
        eom_irq_q <= !eom_q;
      end else if (cmd_rst_eom || (data_wr && ctrl_q.auto_clr)) begin
        eom_q <= 1'b0;
      end
    end
  end

  // shifter: a started character always completes, regardless of tx_en
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q    <= '0;
      bit_cnt_q <= '0;
      sdo_q     <= 1'b1;
    end else if (bit_en_i) begin
      if (bit_cnt_q != '0) begin
        sdo_q     <= sreg_q[DATA_W-2];
        sreg_q    <= {sreg_q[DATA_W-3:0], 1'b0};
        bit_cnt_q <= bit_cnt_q - 1'b1;
      end else if (ctrl_q.tx_en) begin
        sdo_q     <= load_byte[DATA_W-1];
        sreg_q    <= load_byte[DATA_W-2:0];
        bit_cnt_q <= BIT_W'(DATA_W-1);
      end else begin
        sdo_q <= 1'b1;
      end
    end
  end

  assign sdo_o     = sdo_q;
  assign eom_o     = eom_q;
  assign eom_irq_o = eom_irq_q;
  assign ovf_o     = ovf_q;
  assign tx_irq_o  = ctrl_q.irq_empty ? fifo_empty : !fifo_full;
endmodule

// File: rtl/bsync_tx_chk.sv
module bsync_tx_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_i,
  input logic             sdo_o,
  input logic             eom_o,
  input logic             eom_irq_o,
  input logic             ovf_o,
  input logic [CNT_W-1:0] fifo_cnt_i
);
  // R2
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(sdo_o));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R10
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CNT_W'(DEPTH));

  // R7
  eom_irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eom_o) |-> eom_irq_o);

  // R7
  eom_irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eom_irq_o |=> !eom_irq_o);

  // R8
  eom_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eom_o) |-> $past((cmd_valid_i && cmd_i == 2'b10) ||
                           (wr_en_i && wr_addr_i == 2'd0)));
endmodule

bind bsync_tx bsync_tx_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_en_i    (bit_en_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .sdo_o       (sdo_o),
  .eom_o       (eom_o),
  .eom_irq_o   (eom_irq_o),
  .ovf_o       (ovf_o),
  .fifo_cnt_i  (fifo_cnt)
);

// File: tb/bsync_tx_tb.sv
`timescale 1ns/1ps
module bsync_tx_tb;
  localparam logic [7:0] SYNC = 8'h16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = '0;
  logic       bit_en = 1'b1;
  logic       sdo, eom, eom_irq, tx_irq, ovf;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  logic [63:0] hist = '0;
  logic [15:0] run_crc;

  always #2.5 clk = ~clk;

  bsync_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .bit_en_i(bit_en), .sdo_o(sdo), .eom_o(eom), .eom_irq_o(eom_irq),
    .tx_irq_o(tx_irq), .ovf_o(ovf)
  );

  // line capture just after each edge
  always @(posedge clk) begin
    #1;
    hist = {hist[62:0], sdo};
    if (eom_irq) irq_cnt++;
  end

  function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c ^= 16'h8005;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] c);
    cmd_valid = 1'b1; cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bits(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_tx();
    wr(2'd2, 8'h00);
    bits(24);
  endtask

  task automatic t_reset();
    chk(sdo == 1'b1,     "R1 sdo",     sdo, 1);
    chk(eom == 1'b1,     "R1 eom",     eom, 1);
    chk(ovf == 1'b0,     "R1 ovf",     ovf, 0);
    chk(tx_irq == 1'b1,  "R1 tx_irq",  tx_irq, 1);
    chk(eom_irq == 1'b0, "R1 eom_irq", eom_irq, 0);
  endtask

  task automatic t_sync_idle();
    wr(2'd2, 8'h01);
    bits(16);
    chk(hist[15:0] == {SYNC, SYNC}, "R3 sync fill", hist[15:0], {SYNC, SYNC});
    stop_tx();
    chk(sdo == 1'b1, "R2 idle mark", sdo, 1);
    bit_en = 1'b0;
    do_cmd(2'b00);
    bits(3);
    chk(sdo == 1'b1, "R2 no bit_en hold", sdo, 1);
    bit_en = 1'b1;
  endtask

  task automatic t_crc_msg();
    logic [47:0] exp;
    wr(2'd2, 8'h02);
    do_cmd(2'b01);
    do_cmd(2'b10);
    chk(eom == 1'b0, "R8 cmd clear", eom, 0);
    wr(2'd0, 8'h31); wr(2'd0, 8'hC2); wr(2'd0, 8'h5F);
    run_crc = crc_upd(crc_upd(crc_upd(16'h0, 8'h31), 8'hC2), 8'h5F);
    irq_cnt = 0;
    wr(2'd2, 8'h03);
    bits(48);
    exp = {8'h31, 8'hC2, 8'h5F, run_crc, SYNC};
    chk(hist[47:0] == exp, "R4 message+trailer", hist[47:0], exp);
    chk(eom == 1'b1, "R7 latch set", eom, 1);
    chk(irq_cnt == 1, "R7 irq pulse", irq_cnt, 1);
    stop_tx();
  endtask

  task automatic t_no_preset();
    logic [31:0] exp;
    do_cmd(2'b10);
    wr(2'd0, 8'hA5);
    run_crc = crc_upd(run_crc, 8'hA5);
    wr(2'd2, 8'h03);
    bits(32);
    exp = {8'hA5, run_crc, SYNC};
    chk(hist[31:0] == exp, "R6 crc carried over", hist[31:0], exp);
    stop_tx();
  endtask

  task automatic t_load_sample();
    logic [39:0] e1;
    logic [31:0] e2;
    logic [15:0] c;
    do_cmd(2'b01); do_cmd(2'b10);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h12); wr(2'd0, 8'h34);
    c = crc_upd(crc_upd(16'h0, 8'h12), 8'h34);
    wr(2'd2, 8'h03);
    bits(40);
    e1 = {8'h12, 8'h34, c, SYNC};
    chk(hist[39:0] == e1, "R5 included at load", hist[39:0], e1);
    stop_tx();
    do_cmd(2'b01); do_cmd(2'b10);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h99);
    wr(2'd2, 8'h01);
    bits(32);
    e2 = {8'h99, 16'h0000, SYNC};
    chk(hist[31:0] == e2, "R5 excluded at load", hist[31:0], e2);
    stop_tx();
  endtask

  task automatic t_sync_excl_auto();
    logic [47:0] exp;
    logic [15:0] c;
    do_cmd(2'b01);
    chk(eom == 1'b1, "R8 latch set before", eom, 1);
    irq_cnt = 0;
    wr(2'd2, 8'h0B);
    bits(8);
    wr(2'd0, 8'h3C);
    bits(7);
    bits(32);
    c = crc_upd(16'h0, 8'h3C);
    exp = {SYNC, SYNC, 8'h3C, c, SYNC};
    chk(hist[47:0] == exp, "R3 sync excluded, R8 auto clear", hist[47:0], exp);
    chk(irq_cnt == 1, "R7 irq after auto", irq_cnt, 1);
    stop_tx();
  endtask

  task automatic t_cmd_eom();
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h44);
    chk(eom == 1'b1, "R8 write w/o auto keeps latch", eom, 1);
    do_cmd(2'b10);
    chk(eom == 1'b0, "R8 command clears", eom, 0);
    wr(2'd2, 8'h01);
    bits(40);
    stop_tx();
  endtask

  task automatic t_overflow();
    logic [39:0] exp;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hA1); wr(2'd0, 8'hB2); wr(2'd0, 8'hC3); wr(2'd0, 8'hD4);
    chk(tx_irq == 1'b0, "R11 full drops irq", tx_irq, 0);
    chk(ovf == 1'b0, "R10 no ovf at 4", ovf, 0);
    wr(2'd0, 8'hE5);
    chk(ovf == 1'b1, "R10 ovf set", ovf, 1);
    wr(2'd2, 8'h01);
    bits(40);
    exp = {8'hA1, 8'hB2, 8'hC3, 8'hD4, SYNC};
    chk(hist[39:0] == exp, "R10 fifth byte dropped", hist[39:0], exp);
    chk(ovf == 1'b1, "R10 ovf sticky", ovf, 1);
    stop_tx();
  endtask

  task automatic t_irq_modes();
    chk(tx_irq == 1'b1, "R11 mode0 empty", tx_irq, 1);
    wr(2'd0, 8'h55);
    chk(tx_irq == 1'b1, "R11 mode0 one byte", tx_irq, 1);
    wr(2'd2, 8'h04);
    chk(tx_irq == 1'b0, "R11 mode1 one byte", tx_irq, 0);
    wr(2'd2, 8'h05);
    bits(16);
    chk(tx_irq == 1'b1, "R11 mode1 drained", tx_irq, 1);
    stop_tx();
  endtask

  task automatic t_mid_disable();
    wr(2'd2, 8'h01);
    bits(3);
    wr(2'd2, 8'h00);
    bits(12);
    chk(hist[15:0] == {SYNC, 8'hFF}, "R9 char completes", hist[15:0], {SYNC, 8'hFF});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(2'd1, SYNC);
    t_sync_idle();
    t_crc_msg();
    t_no_preset();
    t_load_sample();
    t_sync_excl_auto();
    t_cmd_eom();
    t_irq_modes();
    t_mid_disable();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule